// File: doc/BRIEF.md
# Receive Cell Bus Slave (Four Ports)

This block is the cell-side end of the receive direction of a shared 8-bit cell bus. It serves four ports, and each port has a programmable 5-bit bus address. Each port has an incoming byte stream with a start marker, and these bytes fill a small per-port store of complete 53-byte cells. An external bus master polls the ports by address. It learns from a shared cell-available line whether a port holds a whole cell, then selects one port and pulls that cell out one byte per clock, pausing whenever it likes.

The shared lines are tri-stated in the pad ring. The block supplies each value together with its output enable: one enable for the cell-available line, and one enable for the data, parity and start-of-cell group. A port can be switched away from in the middle of a cell. When it is selected again, it resumes from the byte where it stopped. A cell leaves the store only after its last byte has gone out.

Top module: `cellbus_rx_slave`

## Requirements
- R1: The cell-available enable `rx_clav_oe` is high in the cycle after `rx_addr` equals one of the four programmed addresses (port p's address is `port_addr[5p+4:5p]`). It is low in the cycle after any other address.
- R2: When driven, `rx_clav` is 1 exactly when the polled port holds at least one complete cell, and it refers to the address seen one clock earlier.
- R3: `rx_enb` is active low. A port is selected when its address is on `rx_addr` in a cycle with `rx_enb` high and `rx_enb` is low in the next cycle. A falling enable with any other address deselects, and `rx_bus_oe` stays low.
- R4: Each clock edge that samples `rx_enb` low while a port is selected and holds a cell puts that cell's next byte on `rx_data` after that edge, in arrival order.
- R5: While `rx_enb` is high, `rx_data`, `rx_soc`, `rx_par` and `rx_bus_oe` keep their values.
- R6: `rx_soc` is 1 with byte 0 of each cell and 0 with bytes 1 to 52.
- R7: The nine bits {`rx_par`, `rx_data`} always hold an odd number of ones while `rx_bus_oe` is high.
- R8: A cell is removed only after all 53 bytes have been output. A port that is left mid-cell still reports available and later resumes at the next unsent byte.
- R9: A cell that is incomplete when the next start marker arrives is discarded and never reported. The new cell starts afresh.
- R10: A start marker that arrives while the port already holds two complete cells causes that whole cell to be dropped.
- R11: `rx_bus_oe` is low after reset, when no port is selected, and when the selected port has no cell at an enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_addr | input | 20 | Bus address of each port, 5 bits per port, port 0 in the low bits |
| line_valid | input | 4 | Byte strobe per port from the line side |
| line_sop | input | 4 | Start-of-cell marker per port, valid with line_valid |
| line_data | input | 32 | Byte per port, port 0 in the low byte |
| rx_addr | input | 5 | Address driven by the bus master |
| rx_enb | input | 1 | Transfer enable from the master, active low |
| rx_clav | output | 1 | Cell-available value for the polled port |
| rx_clav_oe | output | 1 | Drive enable of the shared cell-available line |
| rx_data | output | 8 | Cell byte toward the master |
| rx_par | output | 1 | Odd parity over rx_data |
| rx_soc | output | 1 | Marks byte 0 of a cell |
| rx_bus_oe | output | 1 | Drive enable of data, parity and start-of-cell |

## Verification
The bench tries polling with back-to-back addresses that switch between own and foreign ports and between empty and loaded ports. These patterns separate a one-cycle response from a combinational or stale one. Reads are tried without pauses, with random enable gaps, and with interruptions that switch to another port in mid-cell. Together they separate correct pause holding, per-port resume and late removal from designs that drop or repeat bytes. Line-side patterns with truncated cells and over-full stores show whether partial cells and overflow cells are discarded, not stored.

// File: rtl/cellbus_pkg.sv
package cellbus_pkg;
    parameter int unsigned CB_NUM_PORTS  = 4;
    parameter int unsigned CB_ADDR_W     = 5;
    parameter int unsigned CB_DATA_W     = 8;
    parameter int unsigned CB_CELL_BYTES = 53;
    parameter int unsigned CB_FIFO_CELLS = 2;

    // index width that never collapses to zero bits
    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/cellbus_addr_match.sv
module cellbus_addr_match
    import cellbus_pkg::*;
#(
    parameter int unsigned NUM_PORTS = CB_NUM_PORTS,
    parameter int unsigned ADDR_W    = CB_ADDR_W,
    localparam int unsigned IDX_W    = width_of(NUM_PORTS)
) (
    input  logic [NUM_PORTS*ADDR_W-1:0] tbl,
    input  logic [ADDR_W-1:0]           addr,
    output logic                        hit,
    output logic [IDX_W-1:0]            idx
);
    // lowest port index wins when two ports share an address
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (tbl[p*ADDR_W +: ADDR_W] == addr) begin
                hit = 1'b1;
                idx = IDX_W'(p);
            end
        end
    end
endmodule

// File: rtl/cellbus_cell_store.sv
module cellbus_cell_store
    import cellbus_pkg::*;
#(
    parameter int unsigned DATA_W     = CB_DATA_W,
    parameter int unsigned CELL_BYTES = CB_CELL_BYTES,
    parameter int unsigned FIFO_CELLS = CB_FIFO_CELLS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [DATA_W-1:0] in_data,
    input  logic              rd_adv,
    output logic              cell_rdy,
    output logic [DATA_W-1:0] rd_byte,
    output logic              rd_first
);
    localparam int unsigned OFF_W  = width_of(CELL_BYTES);
    localparam int unsigned SLOT_W = width_of(FIFO_CELLS);
    localparam int unsigned CNT_W  = $clog2(FIFO_CELLS + 1);
    localparam int unsigned DEPTH  = CELL_BYTES * FIFO_CELLS;
    localparam int unsigned MA_W   = width_of(DEPTH);
    localparam logic [OFF_W-1:0]  OFF_LAST  = OFF_W'(CELL_BYTES - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(FIFO_CELLS - 1);
    localparam logic [CNT_W-1:0]  CNT_FULL  = CNT_W'(FIFO_CELLS);

    typedef struct packed {
        logic              wr_act;
        logic [OFF_W-1:0]  wr_off;
        logic [SLOT_W-1:0] wr_slot;
        logic [OFF_W-1:0]  rd_off;
        logic [SLOT_W-1:0] rd_slot;
        logic [CNT_W-1:0]  cnt;
    } store_t;

    store_t st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic              mem_we;
    logic [MA_W-1:0]   mem_wa;
    logic              push, pop;

    function automatic logic [MA_W-1:0] slot_addr(input logic [SLOT_W-1:0] s,
                                                 input logic [OFF_W-1:0]  o);
        return MA_W'(s) * MA_W'(CELL_BYTES) + MA_W'(o);
    endfunction

    function automatic logic [SLOT_W-1:0] slot_next(input logic [SLOT_W-1:0] s);
        return (s == SLOT_LAST) ? '0 : s + 1'b1;
    endfunction

    always_comb begin
        st_d   = st_q;
        mem_we = 1'b0;
        mem_wa = slot_addr(st_q.wr_slot, st_q.wr_off);
        push   = 1'b0;
        pop    = 1'b0;
        if (in_valid) begin
            if (in_sop) begin
                // a start marker always restarts the slot; partial data is lost
                mem_wa      = slot_addr(st_q.wr_slot, '0);
                st_d.wr_off = '0;
                st_d.wr_act = 1'b0;
                if (st_q.cnt != CNT_FULL) begin
                    mem_we      = 1'b1;
                    st_d.wr_act = 1'b1;
                    st_d.wr_off = OFF_W'(1);
                end
            end else if (st_q.wr_act) begin
                mem_we = 1'b1;
                if (st_q.wr_off == OFF_LAST) begin
                    st_d.wr_act  = 1'b0;
                    st_d.wr_off  = '0;
                    st_d.wr_slot = slot_next(st_q.wr_slot);
                    push         = 1'b1;
                end else begin
                    st_d.wr_off = st_q.wr_off + 1'b1;
                end
            end
        end
        if (rd_adv && (st_q.cnt != '0)) begin
            if (st_q.rd_off == OFF_LAST) begin
                st_d.rd_off  = '0;
                st_d.rd_slot = slot_next(st_q.rd_slot);
                pop          = 1'b1;
            end else begin
                st_d.rd_off = st_q.rd_off + 1'b1;
            end
        end
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_wa] <= in_data;
    end

    assign cell_rdy = (st_q.cnt != '0);
    assign rd_byte  = mem[slot_addr(st_q.rd_slot, st_q.rd_off)];
    assign rd_first = (st_q.rd_off == '0);
endmodule

// File: rtl/cellbus_rx_slave.sv
module cellbus_rx_slave
    import cellbus_pkg::*;
#(
    parameter int unsigned NUM_PORTS  = CB_NUM_PORTS,
    parameter int unsigned ADDR_W     = CB_ADDR_W,
    parameter int unsigned DATA_W     = CB_DATA_W,
    parameter int unsigned CELL_BYTES = CB_CELL_BYTES,
    parameter int unsigned FIFO_CELLS = CB_FIFO_CELLS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS*ADDR_W-1:0] port_addr,
    input  logic [NUM_PORTS-1:0]        line_valid,
    input  logic [NUM_PORTS-1:0]        line_sop,
    input  logic [NUM_PORTS*DATA_W-1:0] line_data,
    input  logic [ADDR_W-1:0]           rx_addr,
    input  logic                        rx_enb,
    output logic                        rx_clav,
    output logic                        rx_clav_oe,
    output logic [DATA_W-1:0]           rx_data,
    output logic                        rx_par,
    output logic                        rx_soc,
    output logic                        rx_bus_oe
);
    localparam int unsigned IDX_W = width_of(NUM_PORTS);

    typedef struct packed {
        logic              enb;
        logic [ADDR_W-1:0] addr;
        logic              hit;
        logic              avail;
        logic              sel_vld;
        logic [IDX_W-1:0]  sel_idx;
        logic              out_vld;
        logic [DATA_W-1:0] out_data;
        logic              out_soc;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [NUM_PORTS-1:0]             cell_rdy;
    logic [NUM_PORTS-1:0]             rd_first;
    logic [NUM_PORTS-1:0]             rd_adv;
    logic [NUM_PORTS-1:0][DATA_W-1:0] rd_byte;
    logic                             poll_hit, sel_hit;
    logic [IDX_W-1:0]                 poll_idx, sel_idx;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_store
        cellbus_cell_store #(
            .DATA_W    (DATA_W),
            .CELL_BYTES(CELL_BYTES),
            .FIFO_CELLS(FIFO_CELLS)
        ) store_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_valid(line_valid[g]),
            .in_sop  (line_sop[g]),
            .in_data (line_data[g*DATA_W +: DATA_W]),
            .rd_adv  (rd_adv[g]),
            .cell_rdy(cell_rdy[g]),
            .rd_byte (rd_byte[g]),
            .rd_first(rd_first[g])
        );
    end

    // current address for polling, last cycle's address for selection
    cellbus_addr_match #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) poll_match_i (
        .tbl(port_addr), .addr(rx_addr), .hit(poll_hit), .idx(poll_idx)
    );
    cellbus_addr_match #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) sel_match_i (
        .tbl(port_addr), .addr(st_q.addr), .hit(sel_hit), .idx(sel_idx)
    );

    always_comb begin
        st_d       = st_q;
        rd_adv     = '0;
        st_d.enb   = rx_enb;
        st_d.addr  = rx_addr;
        st_d.hit   = poll_hit;
        st_d.avail = poll_hit & cell_rdy[poll_idx];
        if (!rx_enb) begin
            if (st_q.enb) begin
                st_d.sel_vld = sel_hit;
                st_d.sel_idx = sel_idx;
            end
            if (st_d.sel_vld && cell_rdy[st_d.sel_idx]) begin
                st_d.out_vld            = 1'b1;
                st_d.out_data           = rd_byte[st_d.sel_idx];
                st_d.out_soc            = rd_first[st_d.sel_idx];
                rd_adv[st_d.sel_idx]    = 1'b1;
            end else begin
                st_d.out_vld = 1'b0;
                st_d.out_soc = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.enb <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_clav    = st_q.avail;
    assign rx_clav_oe = st_q.hit;
    assign rx_data    = st_q.out_data;
    assign rx_par     = ~^st_q.out_data;
    assign rx_soc     = st_q.out_soc;
    assign rx_bus_oe  = st_q.out_vld;
endmodule

// File: rtl/cellbus_rx_checker.sv
module cellbus_rx_checker #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned DATA_W    = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_PORTS*ADDR_W-1:0] port_addr,
    input logic [ADDR_W-1:0]           rx_addr,
    input logic                        rx_enb,
    input logic                        rx_clav_oe,
    input logic [DATA_W-1:0]           rx_data,
    input logic                        rx_par,
    input logic                        rx_soc,
    input logic                        rx_bus_oe,
    input logic                        sel_vld
);
    function automatic logic is_own(input logic [ADDR_W-1:0] a);
        logic r = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (port_addr[p*ADDR_W +: ADDR_W] == a) r = 1'b1;
        return r;
    endfunction

    assert_poll_own_R1: assert property (@(posedge clk) disable iff (!rst_n)
        is_own(rx_addr) |=> rx_clav_oe);

    assert_poll_foreign_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !is_own(rx_addr) |=> !rx_clav_oe);

    assert_foreign_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enb && $past(rx_enb) && !is_own($past(rx_addr))) |=> !rx_bus_oe);

    assert_pause_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enb && rx_bus_oe) |=> (rx_bus_oe && $stable(rx_data) && $stable(rx_soc)));

    assert_odd_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bus_oe |-> ($countones({rx_par, rx_data}) % 2 == 1));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_vld |-> !rx_bus_oe);
endmodule

bind cellbus_rx_slave cellbus_rx_checker #(
    .NUM_PORTS(NUM_PORTS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_addr (port_addr),
    .rx_addr   (rx_addr),
    .rx_enb    (rx_enb),
    .rx_clav_oe(rx_clav_oe),
    .rx_data   (rx_data),
    .rx_par    (rx_par),
    .rx_soc    (rx_soc),
    .rx_bus_oe (rx_bus_oe),
    .sel_vld   (st_q.sel_vld)
);

// File: tb/cellbus_rx_slave_tb_top.sv
module cellbus_rx_slave_tb_top;
    localparam int NP = 4;
    localparam int AW = 5;
    localparam int DW = 8;
    localparam int CB = 53;
    localparam int FC = 2;
    localparam logic [AW-1:0] FOREIGN = 5'h1F;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP*AW-1:0]  port_addr;
    logic [NP-1:0]     line_valid = '0;
    logic [NP-1:0]     line_sop = '0;
    logic [NP*DW-1:0]  line_data = '0;
    logic [AW-1:0]     rx_addr = FOREIGN;
    logic              rx_enb = 1'b1;
    logic              rx_clav, rx_clav_oe, rx_par, rx_soc, rx_bus_oe;
    logic [DW-1:0]     rx_data;

    logic [AW-1:0] paddr [NP] = '{5'h03, 5'h11, 5'h1A, 5'h07};
    assign port_addr = {paddr[3], paddr[2], paddr[1], paddr[0]};

    int checks = 0;
    int errors = 0;
    int cell_q [NP][$];
    int rd_off [NP] = '{0, 0, 0, 0};
    int next_cid = 1;
    bit done = 1'b0;

    always #10ns clk = ~clk;

    cellbus_rx_slave dut_i (
        .clk(clk), .rst_n(rst_n), .port_addr(port_addr),
        .line_valid(line_valid), .line_sop(line_sop), .line_data(line_data),
        .rx_addr(rx_addr), .rx_enb(rx_enb),
        .rx_clav(rx_clav), .rx_clav_oe(rx_clav_oe), .rx_data(rx_data),
        .rx_par(rx_par), .rx_soc(rx_soc), .rx_bus_oe(rx_bus_oe)
    );

    function automatic logic [7:0] byte_of(input int p, input int cid, input int off);
        return 8'((p * 61 + cid * 29 + off * 7 + off * off) & 255);
    endfunction

    function automatic int own_idx(input logic [AW-1:0] a);
        for (int p = 0; p < NP; p++) if (paddr[p] == a) return p;
        return -1;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // drive one cell (or a truncated one) into a port; the model stores full ones
    task automatic feed(input int p, input int len, input int gap_pct);
        int cid = next_cid++;
        if (len == CB && cell_q[p].size() < FC) cell_q[p].push_back(cid);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            line_valid[p] = 1'b0;
            while ($urandom_range(99) < gap_pct) @(negedge clk);
            line_valid[p] = 1'b1;
            line_sop[p] = (i == 0);
            line_data[p*DW +: DW] = byte_of(p, cid, i);
        end
        @(negedge clk);
        line_valid[p] = 1'b0;
        line_sop[p] = 1'b0;
    endtask

    task automatic poll(input logic [AW-1:0] a, input string req);
        int p = own_idx(a);
        @(negedge clk);
        rx_enb = 1'b1;
        rx_addr = a;
        @(negedge clk);
        chk(req, "clav_oe", int'(rx_clav_oe), int'(p >= 0));
        if (p >= 0) chk(req, "clav", int'(rx_clav), int'(cell_q[p].size() > 0));
    endtask

    // select address a, then pull up to n bytes with random pauses
    task automatic read_run(input logic [AW-1:0] a, input int n, input int pause_pct);
        int p = own_idx(a);
        bit low = 1'b1;
        logic [7:0] held_d = '0;
        logic held_s = 1'b0;
        @(negedge clk);
        rx_enb = 1'b1;
        rx_addr = a;
        @(negedge clk);
        rx_enb = 1'b0;
        for (int k = 0; k < n; ) begin
            @(negedge clk);
            if (low) begin
                if (p < 0 || cell_q[p].size() == 0) begin
                    chk("R11", "bus_oe idle", int'(rx_bus_oe), 0);
                    if (p < 0) chk("R3", "foreign select", int'(rx_bus_oe), 0);
                    k = n;
                end else begin
                    chk("R4", "bus_oe", int'(rx_bus_oe), 1);
                    chk("R4", "data", int'(rx_data),
                        int'(byte_of(p, cell_q[p][0], rd_off[p])));
                    chk("R6", "soc", int'(rx_soc), int'(rd_off[p] == 0));
                    chk("R7", "odd parity", int'(^{rx_par, rx_data}), 1);
                    rd_off[p]++;
                    if (rd_off[p] == CB) begin
                        rd_off[p] = 0;
                        void'(cell_q[p].pop_front());
                    end
                    k++;
                end
            end else begin
                chk("R5", "pause oe", int'(rx_bus_oe), 1);
                chk("R5", "pause data", int'(rx_data), int'(held_d));
                chk("R5", "pause soc", int'(rx_soc), int'(held_s));
            end
            held_d = rx_data;
            held_s = rx_soc;
            low = (k < n) && ($urandom_range(99) >= pause_pct);
            rx_enb = !low;
        end
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            report();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C11));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "reset bus_oe", int'(rx_bus_oe), 0);
        chk("R1", "reset clav_oe", int'(rx_clav_oe), 0);

        // R1 R2: own/foreign and empty/loaded back-to-back polls
        poll(paddr[0], "R2");
        poll(FOREIGN, "R1");
        poll(paddr[2], "R1");

        // R9: truncated cell is dropped, then a full one replaces it
        begin
            int cid = next_cid++;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                line_valid[0] = 1'b1;
                line_sop[0] = (i == 0);
                line_data[DW-1:0] = byte_of(0, cid, i);
            end
            @(negedge clk);
            line_valid[0] = 1'b0;
            line_sop[0] = 1'b0;
        end
        poll(paddr[0], "R9");
        feed(0, CB, 0);
        poll(paddr[0], "R9");
        poll(paddr[1], "R2");
        poll(paddr[0], "R2");

        // R4 R6 R7: whole cell without pauses
        read_run(paddr[0], CB, 0);
        poll(paddr[0], "R8");

        // R10: third cell dropped when two are held
        feed(1, CB, 0);
        feed(1, CB, 10);
        feed(1, CB, 0);
        chk("R10", "model depth", cell_q[1].size(), 2);
        read_run(paddr[1], 2 * CB + 5, 20);
        poll(paddr[1], "R10");

        // R8: switch ports in mid-cell and resume
        feed(0, CB, 0);
        feed(2, CB, 0);
        read_run(paddr[0], 20, 25);
        poll(paddr[0], "R8");
        read_run(paddr[2], CB, 25);
        read_run(paddr[0], CB - 20, 25);
        chk("R8", "resume finished cell", rd_off[0], 0);
        poll(paddr[0], "R8");

        // R3 R11: foreign and empty selections
        read_run(FOREIGN, 4, 0);
        read_run(paddr[3], 4, 0);

        // random mix
        for (int it = 0; it < 160; it++) begin
            int op = $urandom_range(9);
            int p = $urandom_range(NP - 1);
            logic [AW-1:0] a = ($urandom_range(5) == 0) ? FOREIGN : paddr[p];
            if (op < 4) begin
                if ($urandom_range(6) == 0) feed(p, $urandom_range(CB - 1, 1), 15);
                feed(p, CB, 15);
            end else if (op < 6) begin
                poll(a, "R2");
            end else begin
                read_run(a, $urandom_range(80, 1), 30);
            end
        end

        @(negedge clk);
        rx_enb = 1'b1;
        done = 1'b1;
        report();
        $finish;
    end
endmodule